// File: doc/BRIEF.md
# Audio Descriptor-Ring DMA Channel

This block is one bus-master audio playback channel. It works through a ring of 32 buffer descriptors that sit in system memory. Each descriptor gives a buffer start address, a length counted in 16-bit samples and a per-buffer completion-interrupt flag. The channel fetches a descriptor, reads the buffer one sample at a time through a simple word-read memory port, and pushes each sample into a downstream FIFO. When a buffer is used up, the channel moves its current index to the next ring slot.

Software limits how far the channel may go by moving a last-valid index. When the buffer at that index completes, the channel stops and reports that it has halted. Writing a new last-valid index that differs from the current one lets it continue. Software controls the channel through a small register set: a run bit, two interrupt enables, a self-clearing reset bit, and status flags that are cleared by writing a 1. The single interrupt line combines the status flags with their enables.

Top module: `aud_ring_dma`

## Requirements
- R1: After the asynchronous reset, every readable register (base=0, current index=1, last-valid index=2, control=3, status=4, position=5 on the 3-bit address) reads zero, `irq` is low and no memory request is made.
- R2: The two words of descriptor i are read at base+8*i and base+8*i+4. The first word is the buffer address. In the second word, bit 31 is the completion-interrupt flag and bits 15:0 are the length in samples. The base register may be rewritten while the channel is stopped.
- R3: Sample k of a buffer is read from buffer+2*k and taken from bits 31:16 of the returned word when address bit 1 is set, otherwise from bits 15:0. Samples are pushed in order, and only while `fifo_full` is low.
- R4: The current index advances by one, modulo 32, when a buffer that is not at the last-valid index completes. A write to the last-valid index stores the written value modulo 32.
- R5: When the buffer at the last-valid index completes, the channel sets status bit 1 and the halted bit (status bit 0), keeps its current index, and makes no further memory request or push. If run is set and a last-valid index different from the current index is written, the channel steps to the next index and continues.
- R6: The buffer-done status flag (bit 2) is set when a buffer completes only if that buffer's descriptor has its completion-interrupt flag set.
- R7: Writing 1 to status bits 1, 2 or 3 clears those bits. Zero bits in the write leave flags unchanged. The halted bit ignores writes.
- R8: `irq` = (status bit 1 AND control bit 2) OR (status bit 2 AND control bit 3) OR status bit 3.
- R9: Clearing control bit 0 (run) stops the channel at the next sample boundary. The current index and position are kept, and setting run again resumes within the same buffer.
- R10: Writing 1 to control bit 1 resets the channel one cycle later. Control, current index, last-valid index, status and position then read zero, and the base register is kept.
- R11: The position register is loaded with the descriptor length when a descriptor is fetched, and it decreases by one on each sample push.
- R12: A pulse on `fifo_err` sets status bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory word read request, held until acknowledged |
| mem_addr | output | 32 | Memory byte address |
| mem_ack | input | 1 | Memory read acknowledge, data valid |
| mem_rdata | input | 32 | Memory read data |
| fifo_push | output | 1 | Sample push strobe |
| fifo_data | output | 16 | Sample word |
| fifo_full | input | 1 | FIFO cannot accept a sample |
| fifo_err | input | 1 | FIFO error pulse |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check, on every cycle: pushes happen only into a non-full FIFO; the current index only ever steps by one modulo 32 or returns to zero on a channel reset; a halted channel stays quiet; reaching the last-valid buffer leads to the halted state; each push lowers the position by one; the reset bit clears itself; and a FIFO error raises the interrupt. Only the directed scenarios can show the data path and the ordering. Those cover sample order and half-word selection, descriptor addressing from a rewritten base, wrapping of the ring from 31 to 0, a resume after the last-valid index is moved, a pause and resume in the middle of a buffer under FIFO backpressure, the effect of the per-buffer completion flag, and what the self-clearing reset leaves behind.

// File: rtl/ardma_pkg.sv
package ardma_pkg;
  localparam int AW       = 32;
  localparam int RING_LEN = 32;
  localparam int IW       = $clog2(RING_LEN);
  localparam int LW       = 16;
  localparam int SW       = 16;
  localparam int FW       = 3;

  typedef enum logic [2:0] {
    A_BASE = 3'd0, A_CIDX = 3'd1, A_LIDX = 3'd2,
    A_CTRL = 3'd3, A_STAT = 3'd4, A_POS  = 3'd5
  } reg_addr_e;

  typedef enum logic [2:0] {
    E_IDLE, E_DW0, E_DW1, E_SREQ, E_SPUSH
  } eng_st_e;

  localparam int C_RUN  = 0;
  localparam int C_RST  = 1;
  localparam int C_LVIE = 2;
  localparam int C_IOCE = 3;

  // flag vector order: [0]=last-valid done, [1]=buffer done, [2]=fifo error
  localparam int F_LVB = 0;
  localparam int F_BC  = 1;
  localparam int F_FE  = 2;

  function automatic logic [AW-1:0] desc_word_addr(logic [AW-1:0] base,
                                                   logic [IW-1:0] idx,
                                                   logic          second);
    return base + {{(AW-IW-3){1'b0}}, idx, 3'b000}
                + {{(AW-3){1'b0}}, second, 2'b00};
  endfunction

  function automatic logic [AW-1:0] sample_addr(logic [AW-1:0] buf_a,
                                                logic [LW-1:0] k);
    return buf_a + {{(AW-LW-1){1'b0}}, k, 1'b0};
  endfunction

  function automatic logic [IW-1:0] ring_next(logic [IW-1:0] i);
    return i + IW'(1);
  endfunction

  function automatic logic [SW-1:0] pick_half(logic [31:0] w, logic hi);
    return hi ? w[31:16] : w[15:0];
  endfunction

  function automatic logic irq_of(logic [FW-1:0] f, logic lvie, logic ioce);
    return (f[F_LVB] & lvie) | (f[F_BC] & ioce) | f[F_FE];
  endfunction
endpackage

// File: rtl/ardma_regs.sv
module ardma_regs
  import ardma_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [31:0]   wr_data,
  input  logic          evt_bc,
  input  logic          evt_lvb,
  input  logic          fifo_err,
  output logic [AW-1:0] base,
  output logic [IW-1:0] lvi,
  output logic [3:0]    ctrl,
  output logic [FW-1:0] flags,
  output logic          srst,
  output logic          irq
);
  logic [FW-1:0] w1c, setv;

  assign srst = ctrl[C_RST];
  assign w1c  = (wr_en && wr_addr == A_STAT) ? wr_data[FW:1] : '0;
  assign setv = {fifo_err, evt_bc, evt_lvb};
  assign irq  = irq_of(flags, ctrl[C_LVIE], ctrl[C_IOCE]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base  <= '0;
      lvi   <= '0;
      ctrl  <= '0;
      flags <= '0;
    end else if (srst) begin
      lvi   <= '0;
      ctrl  <= '0;
      flags <= '0;
    end else begin
      if (wr_en && wr_addr == A_BASE) base <= wr_data;
      if (wr_en && wr_addr == A_LIDX) lvi  <= wr_data[IW-1:0];
      if (wr_en && wr_addr == A_CTRL) ctrl <= wr_data[3:0];
      flags <= (flags & ~w1c) | setv;
    end
  end
endmodule

// File: rtl/ardma_engine.sv
module ardma_engine
  import ardma_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          run,
  input  logic [AW-1:0] base,
  input  logic [IW-1:0] lvi,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          fifo_push,
  output logic [SW-1:0] fifo_data,
  input  logic          fifo_full,
  output logic [IW-1:0] civ,
  output logic [LW-1:0] pos,
  output logic          halted,
  output logic          evt_bc,
  output logic          evt_lvb
);
  eng_st_e       st;
  logic [AW-1:0] buf_a;
  logic [LW-1:0] off;
  logic          ioc;
  logic [SW-1:0] smp;
  logic          len_zero, buf_done, at_last, resume;
  logic          unused_hi;

  assign unused_hi = ^mem_rdata[30:LW];

  always_comb begin
    mem_req   = (st == E_DW0) || (st == E_DW1) || (st == E_SREQ);
    mem_addr  = (st == E_SREQ) ? sample_addr(buf_a, off)
                               : desc_word_addr(base, civ, st == E_DW1);
    fifo_push = (st == E_SPUSH) && !fifo_full;
    fifo_data = smp;
    len_zero  = (st == E_DW1) && mem_ack && (mem_rdata[LW-1:0] == '0);
    buf_done  = (fifo_push && pos == LW'(1)) || len_zero;
    at_last   = (civ == lvi);
    evt_lvb   = buf_done && at_last;
    evt_bc    = buf_done && (len_zero ? mem_rdata[31] : ioc);
    resume    = halted && run && (lvi != civ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= E_IDLE; civ <= '0; pos <= '0; halted <= 1'b0;
      buf_a <= '0; off <= '0; ioc <= 1'b0; smp <= '0;
    end else if (srst) begin
      st <= E_IDLE; civ <= '0; pos <= '0; halted <= 1'b0;
      buf_a <= '0; off <= '0; ioc <= 1'b0; smp <= '0;
    end else begin
      if (buf_done) begin
        st <= E_IDLE;
        if (at_last) halted <= 1'b1;
        else         civ    <= ring_next(civ);
      end
      unique case (st)
        E_IDLE: begin
          if (resume) begin
            civ    <= ring_next(civ);
            halted <= 1'b0;
            st     <= E_DW0;
          end else if (run && !halted) begin
            st <= (pos != '0) ? E_SREQ : E_DW0;
          end
        end
        E_DW0: if (mem_ack) begin
          buf_a <= mem_rdata;
          st    <= E_DW1;
        end
        E_DW1: if (mem_ack) begin
          ioc <= mem_rdata[31];
          pos <= mem_rdata[LW-1:0];
          off <= '0;
          if (!len_zero) st <= E_SREQ;
        end
        E_SREQ: begin
          if (!run) st <= E_IDLE;
          else if (mem_ack) begin
            smp <= pick_half(mem_rdata, mem_addr[1]);
            st  <= E_SPUSH;
          end
        end
        E_SPUSH: if (!fifo_full) begin
          pos <= pos - LW'(1);
          off <= off + LW'(1);
          if (pos != LW'(1)) st <= E_SREQ;
        end
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aud_ring_dma.sv
module aud_ring_dma
  import ardma_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [2:0]    rd_addr,
  output logic [31:0]   rd_data,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          fifo_push,
  output logic [SW-1:0] fifo_data,
  input  logic          fifo_full,
  input  logic          fifo_err,
  output logic          irq
);
  logic [AW-1:0] base;
  logic [IW-1:0] lvi, civ;
  logic [3:0]    ctrl;
  logic [FW-1:0] flags;
  logic [LW-1:0] pos;
  logic          srst, halted, evt_bc, evt_lvb;

  ardma_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .evt_bc(evt_bc), .evt_lvb(evt_lvb),
    .fifo_err(fifo_err), .base(base), .lvi(lvi), .ctrl(ctrl),
    .flags(flags), .srst(srst), .irq(irq)
  );

  ardma_engine u_eng (
    .clk(clk), .rst_n(rst_n), .srst(srst), .run(ctrl[C_RUN]),
    .base(base), .lvi(lvi), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .fifo_push(fifo_push),
    .fifo_data(fifo_data), .fifo_full(fifo_full), .civ(civ), .pos(pos),
    .halted(halted), .evt_bc(evt_bc), .evt_lvb(evt_lvb)
  );

  always_comb begin
    case (rd_addr)
      A_BASE:  rd_data = base;
      A_CIDX:  rd_data = {{(32-IW){1'b0}}, civ};
      A_LIDX:  rd_data = {{(32-IW){1'b0}}, lvi};
      A_CTRL:  rd_data = {28'd0, ctrl};
      A_STAT:  rd_data = {{(31-FW){1'b0}}, flags, halted};
      A_POS:   rd_data = {{(32-LW){1'b0}}, pos};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ardma_chk.sv
module ardma_chk
  import ardma_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          srst,
  input logic [IW-1:0] civ,
  input logic [LW-1:0] pos,
  input logic          halted,
  input logic          mem_req,
  input logic          fifo_push,
  input logic          fifo_full,
  input logic          fifo_err,
  input logic          evt_lvb,
  input logic          irq
);
  assert_push_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> !fifo_full);

  assert_civ_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (civ != $past(civ)) && !$past(srst) |-> civ == ($past(civ) + IW'(1)));

  assert_halt_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req && !fifo_push);

  assert_last_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_lvb && !srst |=> halted);

  assert_fe_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_err && !srst |=> irq);

  assert_rst_selfclr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> !srst);

  assert_rst_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> civ == '0 && pos == '0 && !halted);

  assert_pos_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push && !srst |=> pos == $past(pos) - LW'(1));
endmodule

bind aud_ring_dma ardma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .srst(srst), .civ(civ), .pos(pos),
  .halted(halted), .mem_req(mem_req), .fifo_push(fifo_push),
  .fifo_full(fifo_full), .fifo_err(fifo_err), .evt_lvb(evt_lvb), .irq(irq)
);

// File: tb/sim_aud_ring_dma.sv
module sim_aud_ring_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        fifo_push;
  logic [15:0] fifo_data;
  logic        fifo_full = 1'b0;
  logic        fifo_err = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  int n_push = 0;
  logic [15:0] got_smp [0:255];
  logic [31:0] mem [0:1023];

  always #2 clk = ~clk;

  aud_ring_dma u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .fifo_push(fifo_push), .fifo_data(fifo_data),
    .fifo_full(fifo_full), .fifo_err(fifo_err), .irq(irq)
  );

  // memory responder: acknowledges one request every other cycle
  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[11:2]];
    end else begin
      mem_ack <= 1'b0;
    end
  end

  always @(posedge clk) begin
    if (fifo_push) begin
      got_smp[n_push[7:0]] <= fifo_data;
      n_push <= n_push + 1;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_halt(input int limit);
    logic [31:0] s;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      rd_reg(3'd4, s);
      if (s[0]) return;
    end
  endtask

  task automatic put_smp(input logic [31:0] a, input logic [15:0] v);
    if (a[1]) mem[a[11:2]][31:16] = v;
    else      mem[a[11:2]][15:0]  = v;
  endtask

  task automatic set_desc(input logic [31:0] b, input int idx,
                          input logic [31:0] buf_a, input logic [15:0] len,
                          input logic ioc);
    logic [31:0] a;
    a = b + 32'(idx) * 8;
    mem[a[11:2]]       = buf_a;
    mem[a[11:2] + 10'd1] = {ioc, 15'd0, len};
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 6; a++) begin
      rd_reg(3'(a), v);
      check("R1", $sformatf("reg %0d after reset", a), v, 32'd0);
    end
    check("R1", "irq after reset", {31'd0, irq}, 32'd0);
    check("R1", "mem_req after reset", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_single;
    logic [31:0] v;
    set_desc(32'h0, 0, 32'h400, 16'd3, 1'b1);
    put_smp(32'h400, 16'h1111);
    put_smp(32'h402, 16'h2222);
    put_smp(32'h404, 16'h3333);
    wr_reg(3'd2, 32'd0);
    wr_reg(3'd3, 32'hD);
    wait_halt(500);
    check("R3", "push count single", n_push, 32'd3);
    check("R3", "sample 0 low half", {16'd0, got_smp[0]}, 32'h1111);
    check("R3", "sample 1 high half", {16'd0, got_smp[1]}, 32'h2222);
    check("R2", "sample 2 from buffer addr", {16'd0, got_smp[2]}, 32'h3333);
    rd_reg(3'd1, v); check("R5", "civ held at last", v, 32'd0);
    rd_reg(3'd4, v); check("R5", "status halted+lvb+bc", v, 32'h7);
    check("R8", "irq with enables", {31'd0, irq}, 32'd1);
    rd_reg(3'd5, v); check("R11", "position at end", v, 32'd0);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    wr_reg(3'd4, 32'h6);
    rd_reg(3'd4, v); check("R7", "w1c clears bits 1,2", v, 32'h1);
    check("R8", "irq low after clear", {31'd0, irq}, 32'd0);
    wr_reg(3'd4, 32'h1);
    rd_reg(3'd4, v); check("R7", "halted ignores write", v, 32'h1);
  endtask

  task automatic t_extend;
    logic [31:0] v;
    int n0;
    n0 = n_push;
    set_desc(32'h0, 1, 32'h500, 16'd2, 1'b0);
    set_desc(32'h0, 2, 32'h600, 16'd2, 1'b1);
    put_smp(32'h500, 16'hA1A1); put_smp(32'h502, 16'hA2A2);
    put_smp(32'h600, 16'hB1B1); put_smp(32'h602, 16'hB2B2);
    wr_reg(3'd2, 32'd2);
    wait_halt(500);
    rd_reg(3'd1, v); check("R4", "civ after extend", v, 32'd2);
    check("R5", "resume pushes", n_push - n0, 32'd4);
    check("R3", "extend order a", {16'd0, got_smp[n0]}, 32'hA1A1);
    check("R3", "extend order d", {16'd0, got_smp[n0 + 3]}, 32'hB2B2);
    rd_reg(3'd4, v); check("R5", "status after extend", v, 32'h7);
    wr_reg(3'd4, 32'h6);
  endtask

  task automatic t_noioc;
    logic [31:0] v;
    set_desc(32'h0, 3, 32'h700, 16'd1, 1'b0);
    put_smp(32'h700, 16'hC0C0);
    wr_reg(3'd2, 32'd3);
    wait_halt(500);
    rd_reg(3'd4, v); check("R6", "no buffer-done without flag", v, 32'h3);
    check("R8", "irq from last-valid flag", {31'd0, irq}, 32'd1);
    wr_reg(3'd3, 32'h9);
    check("R8", "irq masked by lv enable", {31'd0, irq}, 32'd0);
    wr_reg(3'd4, 32'h6);
  endtask

  task automatic t_pause;
    logic [31:0] v;
    int n0;
    n0 = n_push;
    set_desc(32'h0, 4, 32'h800, 16'd5, 1'b1);
    for (int k = 0; k < 5; k++) put_smp(32'h800 + 32'(2 * k), 16'hD000 + 16'(k));
    wr_reg(3'd3, 32'hD);
    wr_reg(3'd2, 32'd4);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (n_push == n0 + 2) break;
    end
    fifo_full = 1'b1;
    repeat (10) @(negedge clk);
    check("R3", "no push while full", n_push - n0, 32'd2);
    wr_reg(3'd3, 32'hC);
    fifo_full = 1'b0;
    repeat (20) @(negedge clk);
    check("R9", "pause after pending sample", n_push - n0, 32'd3);
    rd_reg(3'd5, v); check("R11", "position kept at pause", v, 32'd2);
    rd_reg(3'd1, v); check("R9", "civ kept at pause", v, 32'd4);
    rd_reg(3'd4, v); check("R9", "not halted while paused", v, 32'h0);
    wr_reg(3'd3, 32'hD);
    wait_halt(500);
    check("R9", "resume finishes buffer", n_push - n0, 32'd5);
    check("R9", "resumed sample order", {16'd0, got_smp[n0 + 3]}, 32'hD003);
    check("R9", "last sample", {16'd0, got_smp[n0 + 4]}, 32'hD004);
    rd_reg(3'd4, v); check("R5", "status after pause buffer", v, 32'h7);
    wr_reg(3'd4, 32'h6);
  endtask

  task automatic t_fifoerr;
    logic [31:0] v;
    wr_reg(3'd3, 32'h0);
    @(negedge clk); fifo_err = 1'b1;
    @(negedge clk); fifo_err = 1'b0;
    rd_reg(3'd4, v); check("R12", "fifo error flag", v, 32'h9);
    check("R8", "fifo error irq always enabled", {31'd0, irq}, 32'd1);
    wr_reg(3'd4, 32'h8);
    check("R7", "fifo error cleared", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_srst;
    logic [31:0] v;
    wr_reg(3'd0, 32'hC00);
    wr_reg(3'd2, 32'd5);
    wr_reg(3'd3, 32'h2);
    @(negedge clk);
    rd_reg(3'd3, v); check("R10", "control self-clears", v, 32'd0);
    rd_reg(3'd1, v); check("R10", "civ cleared", v, 32'd0);
    rd_reg(3'd2, v); check("R10", "lvi cleared", v, 32'd0);
    rd_reg(3'd4, v); check("R10", "status cleared", v, 32'd0);
    rd_reg(3'd5, v); check("R10", "position cleared", v, 32'd0);
    rd_reg(3'd0, v); check("R10", "base kept", v, 32'hC00);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    int n0;
    for (int i = 0; i < 32; i++) begin
      set_desc(32'hC00, i, 32'h900 + 32'(2 * i), 16'd1, 1'b0);
      put_smp(32'h900 + 32'(2 * i), 16'hA000 + 16'(i));
    end
    wr_reg(3'd2, 32'd63);
    rd_reg(3'd2, v); check("R4", "lvi stored modulo 32", v, 32'd31);
    n0 = n_push;
    wr_reg(3'd3, 32'h1);
    wait_halt(3000);
    rd_reg(3'd1, v); check("R4", "civ at 31", v, 32'd31);
    check("R2", "full ring pushes", n_push - n0, 32'd32);
    check("R2", "rewritten base desc 31", {16'd0, got_smp[n0 + 31]}, 32'hA01F);
    n0 = n_push;
    wr_reg(3'd2, 32'd1);
    wait_halt(500);
    rd_reg(3'd1, v); check("R4", "civ wrapped to 1", v, 32'd1);
    check("R4", "wrap pushes", n_push - n0, 32'd2);
    check("R4", "wrap reads desc 0", {16'd0, got_smp[n0]}, 32'hA000);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_single;
    t_w1c;
    t_extend;
    t_noioc;
    t_pause;
    t_fifoerr;
    t_srst;
    t_wrap;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule